// File: doc/BRIEF.md
# Dual-Slot Operand Availability Checker

This block sits in the decode stage of a two-wide, in-order issue pipeline. Each cycle it receives up to two decoded instructions, slot 0 being the older. For every source operand it reports whether the value may be read from the register file, must be taken from the bypass network, or is not yet available. It also gives one ready bit per slot. The check is purely combinational from the current inputs and the tracked state, so it runs in the same cycle as execution-pipe assignment.

For each architectural register the block keeps a single countdown of the cycles left until that register's value is committed. When an instruction that writes a register issues, the countdown is loaded from the producer's latency. Issue distance is counted in cycles: the first cycle after the issuing clock edge is distance 1. A consumer at distance d from a producer of latency L stalls while d < L. For the next two cycles the value exists but has not been written back, so the operand is forwarded. After that it is read from the register file. The older slot's destination is also compared against the younger slot's sources within the pair. A flush discards every pending write. The register file and the bypass multiplexers are outside this block. All pins are plain control signals, sampled on the rising clock edge, with an active-low asynchronous reset.

Top module: `opnd_hazard_chk`

## Requirements
- R1: After reset, and whenever no write to the register is pending, a register source reports select code 2'b00 (register file) and a valid slot with no other hazard raises its ready bit.
- R2: A source whose immediate flag is 1 reports select code 2'b11 and never lowers the ready bit, whatever state its register number is in.
- R3: A register source whose last producer issued with latency L reports 2'b10 (wait) at distance d < L, and its slot's ready bit is 0.
- R4: At distance L <= d < L+2 the source reports 2'b01 (bypass) and does not block ready.
- R5: At distance d >= L+2 the source reports 2'b00 (register file).
- R6: When slot 0 is valid and writes register X, a non-immediate slot 1 source equal to X reports 2'b10 and slot 1 is not ready, independent of latency. Immediate sources and slot 0 instructions that do not write are exempt.
- R7: Slot 1 is ready only when slot 0 is ready (in-order issue), even when slot 1's own sources are all available.
- R8: A flush clears every pending write at the clock edge, so all register sources report 2'b00 in the next cycle. A write issued in the same cycle as the flush is also discarded.
- R9: When both slots issue writes to the same register, the latency of slot 1 (the younger) governs. A new write to a register that is already pending restarts its countdown.
- R10: A slot whose valid input is 0 has its ready bit at 0.
- R11: A write is recorded only when the slot's issue and write-enable inputs are both 1 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all pending writes |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_src_a | input | 4 | Slot 0 first source register |
| s0_imm_a | input | 1 | Slot 0 first source is an immediate |
| s0_src_b | input | 4 | Slot 0 second source register |
| s0_imm_b | input | 1 | Slot 0 second source is an immediate |
| s0_wr | input | 1 | Slot 0 writes a destination |
| s0_dst | input | 4 | Slot 0 destination register |
| s0_lat | input | 3 | Slot 0 producer latency in cycles |
| s0_issue | input | 1 | Slot 0 issues this cycle |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_src_a | input | 4 | Slot 1 first source register |
| s1_imm_a | input | 1 | Slot 1 first source is an immediate |
| s1_src_b | input | 4 | Slot 1 second source register |
| s1_imm_b | input | 1 | Slot 1 second source is an immediate |
| s1_wr | input | 1 | Slot 1 writes a destination |
| s1_dst | input | 4 | Slot 1 destination register |
| s1_lat | input | 3 | Slot 1 producer latency in cycles |
| s1_issue | input | 1 | Slot 1 issues this cycle |
| s0_ready | output | 1 | Slot 0 operands available |
| s0_sel_a | output | 2 | Slot 0 first source select code |
| s0_sel_b | output | 2 | Slot 0 second source select code |
| s1_ready | output | 1 | Slot 1 may issue |
| s1_sel_a | output | 2 | Slot 1 first source select code |
| s1_sel_b | output | 2 | Slot 1 second source select code |

## Verification
Forwarding and stalling can coincide in one cycle. This happens either within one instruction, when one source is in its bypass window while the other is still counting down, or across the pair, when slot 0 is ready with a bypassed operand while slot 1 is blocked by slot 0's destination. The bench sets this up by issuing two producers one cycle apart with latencies chosen so that, at the checking cycle, one has just reached its latency and the other has not. It then expects bypass on one source, wait on the other, and the ready bit low. A second case has both slots issue to the same register in one cycle, so that the younger latency's bypass window is judged rather than the older one's stall.

// File: rtl/opnd_hazard_pkg.sv
package opnd_hazard_pkg;

  // Per-operand select code driven towards the operand multiplexers
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,  // read register file
    SEL_BYP  = 2'b01,  // take from bypass network
    SEL_WAIT = 2'b10,  // value not yet produced
    SEL_IMM  = 2'b11   // immediate operand
  } opnd_sel_t;

endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int NUM_REGS   = 16,
  parameter int LAT_W      = 3,
  parameter int COMMIT_DLY = 2,
  localparam int RID_W     = $clog2(NUM_REGS),
  localparam int MAX_LAT   = (1 << LAT_W) - 1,
  localparam int CNT_W     = $clog2(MAX_LAT + COMMIT_DLY + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             wr0_en,
  input  logic [RID_W-1:0]                 wr0_dst,
  input  logic [LAT_W-1:0]                 wr0_lat,
  input  logic                             wr1_en,
  input  logic [RID_W-1:0]                 wr1_dst,
  input  logic [LAT_W-1:0]                 wr1_lat,
  output logic [NUM_REGS-1:0][CNT_W-1:0]   remain
);

  localparam logic [CNT_W-1:0] MAX_LOAD = CNT_W'(MAX_LAT + COMMIT_DLY - 1);

  // Countdown start value: the consumer at distance d sees L+C-d
  function automatic logic [CNT_W-1:0] start_val(input logic [LAT_W-1:0] lat);
    logic [CNT_W-1:0] sum;
    sum = CNT_W'(lat) + CNT_W'(COMMIT_DLY);
    return (sum == '0) ? '0 : sum - 1'b1;
  endfunction

  logic [CNT_W-1:0] load0, load1;
  assign load0 = start_val(wr0_lat);
  assign load1 = start_val(wr1_lat);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit0, hit1;
    assign hit0 = wr0_en && (wr0_dst == RID_W'(i));
    assign hit1 = wr1_en && (wr1_dst == RID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        remain[i] <= '0;
      end else if (flush) begin
        remain[i] <= '0;
      end else if (hit1) begin
        remain[i] <= load1;          // younger write wins
      end else if (hit0) begin
        remain[i] <= load0;
      end else if (remain[i] != '0) begin
        remain[i] <= remain[i] - 1'b1;
      end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      remain[i] <= MAX_LOAD);  // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !hit0 && !hit1 && remain[i] != '0)
        |=> (remain[i] == $past(remain[i]) - 1'b1));  // R5
  end

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (remain == '0));  // R8

endmodule

// File: rtl/hz_src_lookup.sv
module hz_src_lookup
  import opnd_hazard_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int CNT_W      = 4,
  parameter int COMMIT_DLY = 2,
  localparam int RID_W     = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][CNT_W-1:0] remain,
  input  logic [RID_W-1:0]               rid,
  input  logic                           imm,
  input  logic                           pair_hit,
  output opnd_sel_t                      sel
);

  logic [CNT_W-1:0] cnt;
  assign cnt = remain[rid];

  always_comb begin
    if (imm)                                sel = SEL_IMM;
    else if (pair_hit)                      sel = SEL_WAIT;
    else if (cnt == '0)                     sel = SEL_RF;
    else if (cnt <= CNT_W'(COMMIT_DLY))     sel = SEL_BYP;
    else                                    sel = SEL_WAIT;
  end

endmodule

// File: rtl/hz_slot_eval.sv
module hz_slot_eval
  import opnd_hazard_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int CNT_W      = 4,
  parameter int COMMIT_DLY = 2,
  localparam int RID_W     = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][CNT_W-1:0] remain,
  input  logic                           valid,
  input  logic [RID_W-1:0]               src_a,
  input  logic                           imm_a,
  input  logic                           pair_a,
  input  logic [RID_W-1:0]               src_b,
  input  logic                           imm_b,
  input  logic                           pair_b,
  output opnd_sel_t                      sel_a,
  output opnd_sel_t                      sel_b,
  output logic                           ok
);

  hz_src_lookup #(
    .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .COMMIT_DLY(COMMIT_DLY)
  ) u_lk_a (
    .remain(remain), .rid(src_a), .imm(imm_a), .pair_hit(pair_a), .sel(sel_a)
  );

  hz_src_lookup #(
    .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .COMMIT_DLY(COMMIT_DLY)
  ) u_lk_b (
    .remain(remain), .rid(src_b), .imm(imm_b), .pair_hit(pair_b), .sel(sel_b)
  );

  assign ok = valid && (sel_a != SEL_WAIT) && (sel_b != SEL_WAIT);

endmodule

// File: rtl/opnd_hazard_chk.sv
module opnd_hazard_chk
  import opnd_hazard_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int LAT_W      = 3,
  parameter int COMMIT_DLY = 2,
  localparam int RID_W     = $clog2(NUM_REGS),
  localparam int MAX_LAT   = (1 << LAT_W) - 1,
  localparam int CNT_W     = $clog2(MAX_LAT + COMMIT_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             s0_valid,
  input  logic [RID_W-1:0] s0_src_a,
  input  logic             s0_imm_a,
  input  logic [RID_W-1:0] s0_src_b,
  input  logic             s0_imm_b,
  input  logic             s0_wr,
  input  logic [RID_W-1:0] s0_dst,
  input  logic [LAT_W-1:0] s0_lat,
  input  logic             s0_issue,
  input  logic             s1_valid,
  input  logic [RID_W-1:0] s1_src_a,
  input  logic             s1_imm_a,
  input  logic [RID_W-1:0] s1_src_b,
  input  logic             s1_imm_b,
  input  logic             s1_wr,
  input  logic [RID_W-1:0] s1_dst,
  input  logic [LAT_W-1:0] s1_lat,
  input  logic             s1_issue,
  output logic             s0_ready,
  output logic [1:0]       s0_sel_a,
  output logic [1:0]       s0_sel_b,
  output logic             s1_ready,
  output logic [1:0]       s1_sel_a,
  output logic [1:0]       s1_sel_b
);

  logic [NUM_REGS-1:0][CNT_W-1:0] remain;

  hz_scoreboard #(
    .NUM_REGS(NUM_REGS), .LAT_W(LAT_W), .COMMIT_DLY(COMMIT_DLY)
  ) u_sb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr0_en(s0_issue && s0_wr), .wr0_dst(s0_dst), .wr0_lat(s0_lat),
    .wr1_en(s1_issue && s1_wr), .wr1_dst(s1_dst), .wr1_lat(s1_lat),
    .remain(remain)
  );

  // Older slot's destination against younger slot's sources
  logic pair_wr, pair_a, pair_b;
  assign pair_wr = s0_valid && s0_wr;
  assign pair_a  = pair_wr && (s1_src_a == s0_dst);
  assign pair_b  = pair_wr && (s1_src_b == s0_dst);

  opnd_sel_t sel0_a, sel0_b, sel1_a, sel1_b;
  logic      ok0, ok1;

  hz_slot_eval #(
    .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .COMMIT_DLY(COMMIT_DLY)
  ) u_slot0 (
    .remain(remain), .valid(s0_valid),
    .src_a(s0_src_a), .imm_a(s0_imm_a), .pair_a(1'b0),
    .src_b(s0_src_b), .imm_b(s0_imm_b), .pair_b(1'b0),
    .sel_a(sel0_a), .sel_b(sel0_b), .ok(ok0)
  );

  hz_slot_eval #(
    .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .COMMIT_DLY(COMMIT_DLY)
  ) u_slot1 (
    .remain(remain), .valid(s1_valid),
    .src_a(s1_src_a), .imm_a(s1_imm_a), .pair_a(pair_a),
    .src_b(s1_src_b), .imm_b(s1_imm_b), .pair_b(pair_b),
    .sel_a(sel1_a), .sel_b(sel1_b), .ok(ok1)
  );

  assign s0_ready = ok0;
  assign s1_ready = ok1 && ok0;   // in-order: younger never passes older
  assign s0_sel_a = sel0_a;
  assign s0_sel_b = sel0_b;
  assign s1_sel_a = sel1_a;
  assign s1_sel_b = sel1_b;

  AST_PAIR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_a && !s1_imm_a) |-> !s1_ready);  // R6

  AST_ISSUE0_READY: assert property (@(posedge clk) disable iff (!rst_n)
    s0_issue |-> s0_ready);  // R3

  AST_ISSUE1_READY: assert property (@(posedge clk) disable iff (!rst_n)
    s1_issue |-> s1_ready);  // R7

endmodule

// File: tb/opnd_hazard_chk_bench.sv
module opnd_hazard_chk_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_RF = 2'b00, C_BYP = 2'b01, C_WAIT = 2'b10, C_IMM = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, flush;
  logic s0_valid, s0_imm_a, s0_imm_b, s0_wr, s0_issue;
  logic s1_valid, s1_imm_a, s1_imm_b, s1_wr, s1_issue;
  logic [3:0] s0_src_a, s0_src_b, s0_dst, s1_src_a, s1_src_b, s1_dst;
  logic [2:0] s0_lat, s1_lat;
  logic s0_ready, s1_ready;
  logic [1:0] s0_sel_a, s0_sel_b, s1_sel_a, s1_sel_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_hazard_chk u_opnd_hazard_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .s0_valid(s0_valid), .s0_src_a(s0_src_a), .s0_imm_a(s0_imm_a),
    .s0_src_b(s0_src_b), .s0_imm_b(s0_imm_b), .s0_wr(s0_wr),
    .s0_dst(s0_dst), .s0_lat(s0_lat), .s0_issue(s0_issue),
    .s1_valid(s1_valid), .s1_src_a(s1_src_a), .s1_imm_a(s1_imm_a),
    .s1_src_b(s1_src_b), .s1_imm_b(s1_imm_b), .s1_wr(s1_wr),
    .s1_dst(s1_dst), .s1_lat(s1_lat), .s1_issue(s1_issue),
    .s0_ready(s0_ready), .s0_sel_a(s0_sel_a), .s0_sel_b(s0_sel_b),
    .s1_ready(s1_ready), .s1_sel_a(s1_sel_a), .s1_sel_b(s1_sel_b)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input int d, input int lat);
    if (d < lat)          return C_WAIT;
    else if (d < lat + 2) return C_BYP;
    else                  return C_RF;
  endfunction

  task automatic idle();
    flush = 0;
    s0_valid = 0; s0_imm_a = 1; s0_imm_b = 1; s0_wr = 0; s0_issue = 0;
    s0_src_a = 0; s0_src_b = 0; s0_dst = 0; s0_lat = 0;
    s1_valid = 0; s1_imm_a = 1; s1_imm_b = 1; s1_wr = 0; s1_issue = 0;
    s1_src_a = 0; s1_src_b = 0; s1_dst = 0; s1_lat = 0;
  endtask

  // Next negedge, inputs cleared
  task automatic next_cycle();
    @(negedge clk);
    idle();
  endtask

  // Issue a write from slot 0 at the coming edge
  task automatic do_write(input logic [3:0] dst, input logic [2:0] lat);
    next_cycle();
    s0_valid = 1; s0_wr = 1; s0_dst = dst; s0_lat = lat; s0_issue = 1;
  endtask

  task automatic drain();
    repeat (12) next_cycle();
  endtask

  task automatic t_reset();
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd3;
    s1_valid = 1; s1_imm_b = 0; s1_src_b = 4'd4;
    #1;
    check("R1", "s0_sel_a idle", s0_sel_a, C_RF);
    check("R1", "s0_ready idle", s0_ready, 1);
    check("R1", "s1_sel_b idle", s1_sel_b, C_RF);
    check("R1", "s1_ready idle", s1_ready, 1);
    next_cycle();
    s0_imm_a = 0; s0_src_a = 4'd3;
    #1;
    check("R10", "s0_ready invalid", s0_ready, 0);
  endtask

  task automatic t_imm();
    do_write(4'd2, 3'd5);
    next_cycle();
    s0_valid = 1; s0_imm_a = 1; s0_src_a = 4'd2;
    #1;
    check("R2", "imm sel", s0_sel_a, C_IMM);
    check("R2", "imm ready", s0_ready, 1);
    s0_imm_b = 0; s0_src_b = 4'd2;
    #1;
    check("R3", "reg sel beside imm", s0_sel_b, C_WAIT);
    drain();
  endtask

  task automatic t_latency(input logic [2:0] lat);
    do_write(4'd7, lat);
    for (int d = 1; d <= int'(lat) + 3; d++) begin
      logic [1:0] e;
      next_cycle();
      s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd7;
      #1;
      e = exp_sel(d, int'(lat));
      check(e == C_WAIT ? "R3" : (e == C_BYP ? "R4" : "R5"), "latency sel", s0_sel_a, e);
      check(e == C_WAIT ? "R3" : "R4", "latency ready", s0_ready, (e == C_WAIT) ? 0 : 1);
    end
    drain();
  endtask

  task automatic t_pair();
    next_cycle();
    s0_valid = 1; s0_wr = 1; s0_dst = 4'd5; s0_lat = 3'd1;
    s1_valid = 1; s1_imm_a = 0; s1_src_a = 4'd5;
    #1;
    check("R6", "pair sel", s1_sel_a, C_WAIT);
    check("R6", "pair s1_ready", s1_ready, 0);
    check("R6", "pair s0_ready", s0_ready, 1);
    s1_imm_a = 1;
    #1;
    check("R6", "pair imm exempt", s1_ready, 1);
    s1_imm_a = 0; s1_src_a = 4'd6;
    #1;
    check("R6", "pair other reg", s1_ready, 1);
    s1_src_a = 4'd5; s0_wr = 0;
    #1;
    check("R6", "pair no write", s1_sel_a, C_RF);
    next_cycle();
    s0_valid = 1; s0_wr = 1; s0_dst = 4'd9; s0_lat = 3'd4;  // wr without issue
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd9;
    #1;
    check("R11", "no issue no record", s0_sel_a, C_RF);
  endtask

  task automatic t_inorder();
    do_write(4'd8, 3'd4);
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd8;
    s1_valid = 1; s1_imm_a = 0; s1_src_a = 4'd9;
    #1;
    check("R7", "s1 own sel", s1_sel_a, C_RF);
    check("R7", "s1 blocked by s0", s1_ready, 0);
    drain();
  endtask

  task automatic t_flush();
    do_write(4'd10, 3'd7);
    next_cycle();
    flush = 1;
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd10;
    #1;
    check("R8", "before flush edge", s0_sel_a, C_WAIT);
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd10;
    #1;
    check("R8", "after flush", s0_sel_a, C_RF);
    do_write(4'd15, 3'd3);
    flush = 1;
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd15;
    #1;
    check("R8", "write under flush", s0_sel_a, C_RF);
  endtask

  task automatic t_same_dst();
    next_cycle();
    s0_valid = 1; s0_wr = 1; s0_dst = 4'd11; s0_lat = 3'd7; s0_issue = 1;
    s1_valid = 1; s1_wr = 1; s1_dst = 4'd11; s1_lat = 3'd1; s1_issue = 1;
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd11;
    #1;
    check("R9", "younger latency d1", s0_sel_a, C_BYP);
    next_cycle(); next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd11;
    #1;
    check("R9", "younger latency d3", s0_sel_a, C_RF);
    do_write(4'd12, 3'd1);
    do_write(4'd12, 3'd4);
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd12;
    #1;
    check("R9", "restart d1", s0_sel_a, C_WAIT);
    next_cycle(); next_cycle(); next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd12;
    #1;
    check("R9", "restart d4", s0_sel_a, C_BYP);
    drain();
  endtask

  task automatic t_mixed();
    do_write(4'd13, 3'd2);
    do_write(4'd14, 3'd5);
    next_cycle();
    s0_valid = 1; s0_imm_a = 0; s0_src_a = 4'd13; s0_imm_b = 0; s0_src_b = 4'd14;
    #1;
    check("R4", "mixed bypass", s0_sel_a, C_BYP);
    check("R3", "mixed wait", s0_sel_b, C_WAIT);
    check("R3", "mixed ready", s0_ready, 0);
    s0_imm_b = 1; s0_wr = 1; s0_dst = 4'd1;
    s1_valid = 1; s1_imm_b = 0; s1_src_b = 4'd1;
    #1;
    check("R4", "fwd with pair stall s0", s0_ready, 1);
    check("R6", "fwd with pair stall s1", s1_ready, 0);
    drain();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_imm();
    t_latency(3'd3);
    t_latency(3'd1);
    t_latency(3'd7);
    t_pair();
    t_inorder();
    t_flush();
    t_same_dst();
    t_mixed();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule